// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block sits between synchronous on-chip logic and an external asynchronous static RAM of 64K words by 16 bits. The RAM has a single shared three-state data bus, and its control pins are all active low: a chip select, a write enable, an output enable and one select for each byte lane. On the internal side the block accepts one word request at a time. A request carries an address, write data, a two-bit byte mask and a read/write flag. The block answers each request with a one-cycle done pulse and, for reads, a registered data word.

The RAM timing is turned into whole clock counts, set by parameters. These counts are the address and select setup before the write pulse, the width of the write pulse, the hold after the pulse, the read access time and the bus turnaround after a read. Output enable stays high during every write, so the shorter write pulse applies. The pad's data drivers turn on only after the RAM has had time to release the bus, so the two sides never drive it together. A request whose mask selects no lane completes without touching the RAM.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, req_ready is 1, ram_cs_n, ram_we_n and ram_oe_n are 1, ram_bsel_n is 2'b11 and ram_dq_oe is 0.
- R2: A write with a non-zero mask holds ram_cs_n, ram_bsel_n and ram_addr for SETUP_CYC cycles (default 1) before ram_we_n goes low. ram_we_n then stays low for WP_CYC cycles (default 1). All three stay unchanged for HOLD_CYC cycles (default 1) after ram_we_n rises. ram_oe_n is 1 throughout. rsp_done rises SETUP_CYC+WP_CYC+HOLD_CYC+1 cycles after acceptance (4 by default).
- R3: ram_dq_oe is 1 from the cycle in which ram_we_n falls through the cycle after it rises. ram_dq_out carries the request's write data and is stable while ram_dq_oe is 1.
- R4: Mask bit 0 enables the lower lane (data bits 7:0), and ram_bsel_n[0] low selects it. Mask bit 1 enables the upper lane (bits 15:8), and ram_bsel_n[1] low selects it. A lane whose mask bit is 0 is left unchanged in the RAM by a write.
- R5: A read with a non-zero mask holds ram_cs_n, ram_oe_n and the selected ram_bsel_n low for RD_CYC cycles (default 2), with ram_we_n high. The block samples ram_dq_in on the last of those edges. rsp_rdata then shows the selected lanes, with each unselected lane reading as 8'h00. rsp_done rises RD_CYC+1 cycles after acceptance (3 by default).
- R6: After a read releases the RAM, req_ready stays low for TURN_CYC cycles (default 1). ram_dq_oe does not rise unless ram_oe_n was high in the previous cycle.
- R7: A request with mask 2'b00 raises rsp_done in the cycle after acceptance. It asserts none of ram_cs_n, ram_we_n or ram_oe_n and leaves the RAM contents unchanged. A read of this kind returns 16'h0000.
- R8: rsp_done is high for exactly one cycle per request. A request is taken only on a clock edge at which req_valid and req_ready are both high.
- R9: ram_dq_oe is never 1 while ram_oe_n is 0, and ram_we_n is never 0 while ram_oe_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Registered read data, disabled lanes zero |
| ram_addr | output | 16 | RAM address lines |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_bsel_n | output | 2 | RAM byte selects, bit 0 lower, bit 1 upper, active low |
| ram_dq_out | output | 16 | Data toward the pad driver |
| ram_dq_oe | output | 1 | Pad driver enable |
| ram_dq_in | input | 16 | Data from the pad receiver |

## Verification
The bench sweeps every mask on 32 addresses, writing and then reading back, against a RAM model whose data turns valid only after more than 10 ns of read strobes. A controller that samples one cycle early therefore returns the model's filler pattern. A wrong lane mapping or a write to a disabled lane shows up as corrupted bytes in the readback. The bench also flags any driver overlap with the RAM's output enable, missing drive during the write pulse, a short turnaround after a read, and any strobe seen during a zero-mask request.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RACC   = 3'd4,
        ST_TURN   = 3'd5
    } ctrl_state_e;

endpackage

// File: rtl/sram_lane_sel.sv
module sram_lane_sel #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] sel_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign sel_n[i] = ~mask[i];
    end
endmodule

// File: rtl/sram_lane_merge.sv
module sram_lane_merge #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0]   mask,
    input  logic [LANES*8-1:0] raw,
    output logic [LANES*8-1:0] merged
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[i*8 +: 8] = mask[i] ? raw[i*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1,
    parameter int WP_CYC    = 1,
    parameter int HOLD_CYC  = 1,
    parameter int RD_CYC    = 2,
    parameter int TURN_CYC  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic                req_ready,
    output logic                rsp_done,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic                ram_cs_n,
    output logic                ram_we_n,
    output logic                ram_oe_n,
    output logic [DATA_W/8-1:0] ram_bsel_n,
    output logic [DATA_W-1:0]   ram_dq_out,
    output logic                ram_dq_oe,
    input  logic [DATA_W-1:0]   ram_dq_in
);
    localparam int LANES  = DATA_W / 8;
    localparam int MAX_A  = (SETUP_CYC > WP_CYC) ? SETUP_CYC : WP_CYC;
    localparam int MAX_B  = (HOLD_CYC > RD_CYC) ? HOLD_CYC : RD_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CY = (MAX_C > TURN_CYC) ? MAX_C : TURN_CYC;
    localparam int CNT_W  = $clog2(MAX_CY + 1);

    typedef struct packed {
        ctrl_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  mask;
        logic [LANES-1:0]  lanes_n;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        state:   ST_IDLE,
        cnt:     '0,
        addr:    '0,
        wdata:   '0,
        mask:    '0,
        lanes_n: '1,
        cs_n:    1'b1,
        we_n:    1'b1,
        oe_n:    1'b1,
        dq_oe:   1'b0,
        rdata:   '0,
        done:    1'b0
    };

    ctrl_t q, d;

    logic [LANES-1:0]  req_sel_n;
    logic [DATA_W-1:0] rd_merged;

    sram_lane_sel #(.LANES(LANES)) i_sel (
        .mask  (req_mask),
        .sel_n (req_sel_n)
    );

    sram_lane_merge #(.LANES(LANES)) i_merge (
        .mask   (q.mask),
        .raw    (ram_dq_in),
        .merged (rd_merged)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.mask  = req_mask;
                    if (req_mask == '0) begin
                        d.done = 1'b1;
                        if (!req_write) d.rdata = '0;
                    end else if (req_write) begin
                        d.state   = ST_WSETUP;
                        d.cs_n    = 1'b0;
                        d.lanes_n = req_sel_n;
                        d.cnt     = CNT_W'(SETUP_CYC - 1);
                    end else begin
                        d.state   = ST_RACC;
                        d.cs_n    = 1'b0;
                        d.oe_n    = 1'b0;
                        d.lanes_n = req_sel_n;
                        d.cnt     = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_WSETUP: begin
                if (q.cnt == '0) begin
                    d.state = ST_WPULSE;
                    d.we_n  = 1'b0;
                    d.dq_oe = 1'b1;
                    d.cnt   = CNT_W'(WP_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WPULSE: begin
                if (q.cnt == '0) begin
                    d.state = ST_WHOLD;
                    d.we_n  = 1'b1;
                    d.cnt   = CNT_W'(HOLD_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WHOLD: begin
                if (q.cnt == '0) begin
                    d.state   = ST_IDLE;
                    d.cs_n    = 1'b1;
                    d.lanes_n = '1;
                    d.dq_oe   = 1'b0;
                    d.done    = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RACC: begin
                if (q.cnt == '0) begin
                    d.rdata   = rd_merged;
                    d.done    = 1'b1;
                    d.cs_n    = 1'b1;
                    d.oe_n    = 1'b1;
                    d.lanes_n = '1;
                    d.state   = (TURN_CYC > 0) ? ST_TURN : ST_IDLE;
                    d.cnt     = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_TURN: begin
                if (q.cnt == '0) begin
                    d.state = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTRL_RST;
        else        q <= d;
    end

    assign req_ready  = (q.state == ST_IDLE);
    assign rsp_done   = q.done;
    assign rsp_rdata  = q.rdata;
    assign ram_addr   = q.addr;
    assign ram_cs_n   = q.cs_n;
    assign ram_we_n   = q.we_n;
    assign ram_oe_n   = q.oe_n;
    assign ram_bsel_n = q.lanes_n;
    assign ram_dq_out = q.wdata;
    assign ram_dq_oe  = q.dq_oe;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && (ram_bsel_n == '1)));

    a_r2_setup_before_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_we_n) |-> (!ram_cs_n && $past(!ram_cs_n) && $stable(ram_addr) && $stable(ram_bsel_n)));

    a_r2_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (!ram_cs_n && $stable(ram_addr) && $stable(ram_bsel_n)));

    a_r3_drive_through_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (ram_dq_oe && $stable(ram_dq_out)));

    a_r6_turn_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_dq_oe) |-> ($past(ram_oe_n) && ram_oe_n));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (!ram_dq_oe && ram_we_n));

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata, ram_addr, ram_dq_out, ram_dq_in;
    logic        ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [1:0]  ram_bsel_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] mem     [0:255];
    logic [15:0] ref_mem [0:255];
    int  rd_age = 0;
    int  oe_gap = 10;
    bit  strobe_seen = 0;
    logic prev_dq_oe = 1'b0;

    always #4 clk = ~clk;

    sram_lane_ctrl i_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_bsel_n(ram_bsel_n), .ram_dq_out(ram_dq_out),
        .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // RAM model: data valid only after more than 10 ns of read strobes
    wire rd_active = !ram_cs_n && !ram_oe_n && ram_we_n && (ram_bsel_n != 2'b11);
    logic [15:0] rd_word;
    always_comb begin
        rd_word = mem[ram_addr[7:0]];
        if (ram_bsel_n[0]) rd_word[7:0]  = 8'hEE;
        if (ram_bsel_n[1]) rd_word[15:8] = 8'hEE;
    end
    assign ram_dq_in = (rd_active && rd_age >= 2) ? rd_word : 16'h5A5A;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_active) rd_age <= rd_age + 1; else rd_age <= 0;
            if (!ram_cs_n || !ram_we_n || !ram_oe_n) strobe_seen = 1;
            if (!ram_cs_n && !ram_we_n && ram_bsel_n != 2'b11) begin
                check(ram_dq_oe, "R3 drive during write pulse", {15'd0, ram_dq_oe}, 16'd1);
                check(ram_oe_n, "R2 oe high during write", {15'd0, ram_oe_n}, 16'd1);
                if (!ram_bsel_n[0]) mem[ram_addr[7:0]][7:0]  <= ram_dq_out[7:0];
                if (!ram_bsel_n[1]) mem[ram_addr[7:0]][15:8] <= ram_dq_out[15:8];
            end
            if (ram_dq_oe && !ram_oe_n)
                check(1'b0, "R9 bus contention", 16'd1, 16'd0);
            if (ram_dq_oe && !prev_dq_oe)
                check(oe_gap >= 1, "R6 turnaround gap", 16'(oe_gap), 16'd1);
            if (!ram_oe_n) oe_gap = 0; else if (oe_gap < 100) oe_gap = oe_gap + 1;
            prev_dq_oe = ram_dq_oe;
        end
    end

    task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] dat,
                         input logic [1:0] m, output int lat, output logic [15:0] rd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat; req_mask = m;
        strobe_seen = 0;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
    endtask

    function automatic logic [15:0] merge_exp(input logic [15:0] w, input logic [1:0] m);
        return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [15:0] rd;
        for (int i = 0; i < 256; i++) begin
            mem[i]     = {8'(i) ^ 8'hA5, 8'(i)};
            ref_mem[i] = {8'(i) ^ 8'hA5, 8'(i)};
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset and idle state
        check(req_ready, "R1 ready after reset", {15'd0, req_ready}, 16'd1);
        check({ram_cs_n, ram_we_n, ram_oe_n} == 3'b111, "R1 strobes idle",
              {13'd0, ram_cs_n, ram_we_n, ram_oe_n}, 16'd7);
        check(ram_bsel_n == 2'b11, "R1 lane selects idle", {14'd0, ram_bsel_n}, 16'd3);
        check(!ram_dq_oe, "R1 drivers off", {15'd0, ram_dq_oe}, 16'd0);
        check(!rsp_done, "R8 no done when idle", {15'd0, rsp_done}, 16'd0);

        // write sweep, every mask on 32 addresses
        for (int a = 0; a < 32; a++) begin
            for (int m = 0; m < 4; m++) begin
                logic [15:0] w;
                w = 16'(a * 16'h1357 + m * 16'h0F0F + 16'h2468);
                do_op(1'b1, 16'(a), w, 2'(m), lat, rd);
                if (m == 0) begin
                    check(lat == 1, "R7 zero-mask write latency", 16'(lat), 16'd1);
                    check(!strobe_seen, "R7 no strobes on zero mask", 16'(strobe_seen), 16'd0);
                end else begin
                    check(lat == 4, "R2 write latency", 16'(lat), 16'd4);
                    if (m[0]) ref_mem[a][7:0]  = w[7:0];
                    if (m[1]) ref_mem[a][15:8] = w[15:8];
                end
                @(negedge clk);
                check(!rsp_done, "R8 done single cycle", {15'd0, rsp_done}, 16'd0);
                check(req_ready, "R1 idle after write", {15'd0, req_ready}, 16'd1);
            end
        end

        // read sweep with every mask; R4 lane contents, R5 data and timing
        for (int a = 0; a < 32; a++) begin
            for (int m = 3; m >= 0; m--) begin
                do_op(1'b0, 16'(a), 16'hFFFF, 2'(m), lat, rd);
                if (m == 0) begin
                    check(lat == 1, "R7 zero-mask read latency", 16'(lat), 16'd1);
                    check(rd == 16'h0000, "R7 zero-mask read data", rd, 16'h0000);
                    check(!strobe_seen, "R7 no strobes on zero-mask read", 16'(strobe_seen), 16'd0);
                end else begin
                    check(lat == 3, "R5 read latency", 16'(lat), 16'd3);
                    check(rd == merge_exp(ref_mem[a], 2'(m)), "R4 R5 read data",
                          rd, merge_exp(ref_mem[a], 2'(m)));
                    check(!req_ready, "R6 busy during turnaround", {15'd0, req_ready}, 16'd0);
                end
                @(negedge clk);
                check(!rsp_done, "R8 done single cycle after read", {15'd0, rsp_done}, 16'd0);
                check(req_ready, "R6 ready after turnaround", {15'd0, req_ready}, 16'd1);
                check(rsp_rdata == rd, "R5 read data held", rsp_rdata, rd);
            end
        end

        // read immediately followed by write to the same word
        do_op(1'b0, 16'd40, 16'h0, 2'b11, lat, rd);
        check(rd == ref_mem[40], "R5 read before turnaround write", rd, ref_mem[40]);
        do_op(1'b1, 16'd40, 16'hC3D2, 2'b10, lat, rd);
        ref_mem[40][15:8] = 8'hC3;
        do_op(1'b0, 16'd40, 16'h0, 2'b11, lat, rd);
        check(rd == ref_mem[40], "R4 upper lane only written", rd, ref_mem[40]);

        // R8: with no request, the RAM stays untouched
        strobe_seen = 0;
        repeat (6) @(negedge clk);
        check(!strobe_seen && !rsp_done, "R8 no activity without valid", 16'(strobe_seen), 16'd0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule